// File: doc/BRIEF.md
# Serial Control Register Bank

This block is a slave serial port that gives a host access to a small bank of control registers. The host owns the serial clock. It pulls the active-low frame sync low and shifts in a fixed-length frame, MSB first, one bit per rising clock edge. The frame opens with an access-direction bit and a bank select field. A data word of register width follows.

A write frame stores its data word in the selected register once the last bit has arrived. A read frame uses the data slots differently: the host keeps clocking, and the block returns the selected register on a dedicated return line. Each returned bit is launched on the falling edge ahead of its slot, so the host can sample it on the rising edge.

Select codes above the implemented bank count are harmless. A frame that the host abandons early leaves every register untouched. The active-low reset puts the whole bank back to zero.

Top module: `ctrl_serial_regs`

## Requirements
- R1: Bits are taken on rising `sclk` edges while `fsync_n` is low. Frame bit 15 (sent first) is the direction bit, where 0 means write and 1 means read. Bits 14..12 are the select code, MSB first. Bits 11..0 are the data word, MSB first.
- R2: A write frame (direction 0) with select code 0 to 3 loads its 12-bit data word into that register on the rising edge that takes frame bit 0 (the 16th bit).
- R3: A read frame (direction 1) returns the selected register on `sdo`, MSB first. Register bit 11-k is driven from the falling edge that precedes the rising edge of frame slot 4+k, for k = 0..11.
- R4: `sdo` is low at all other times: in the four header slots, throughout write frames, after the last slot, and while `fsync_n` is high.
- R5: Select codes 4 to 7 have no effect when written, and they read back as all zeros.
- R6: If `fsync_n` is high at any rising edge before the 16th bit has been taken, the frame is discarded and no register changes.
- R7: While `rst_n` is low, all four registers are held at zero and `sdo` is low. This takes effect without waiting for a clock edge.
- R8: A read frame leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock from the host; it also clocks the register bank |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_n | input | 1 | Active-low frame sync |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial readback data, launched on falling edges |

## Verification
Two events can share one rising edge: the capture of a frame's final bit and the return of `fsync_n` high that ends the frame. The bench provokes the collision by raising the sync in the slot where the 16th bit would be taken, after 15 bits have been shifted. A following read of the same bank must still show the old value. The same early abort is also applied at random frame lengths, in both read and write frames, and each result is compared with a bench model that treats every short frame as never sent.

// File: rtl/ctrl_serial_pkg.sv
package ctrl_serial_pkg;

   typedef enum logic {
      ACC_WRITE = 1'b0,
      ACC_READ  = 1'b1
   } acc_e;

   function automatic int frame_bits(input int sel_w, input int data_w);
      return 1 + sel_w + data_w;
   endfunction

endpackage

// File: rtl/ctrl_frame_rx.sv
module ctrl_frame_rx #(
   parameter int SEL_W   = 3,
   parameter int DATA_W  = 12,
   parameter int FRAME_W = ctrl_serial_pkg::frame_bits(SEL_W, DATA_W),
   parameter int CW      = $clog2(FRAME_W)
) (
   input  logic               sclk,
   input  logic               rst_n,
   input  logic               fsync_n,
   input  logic               sdi,
   output logic [CW-1:0]      cnt,
   output logic               hdr_done,
   output logic               frame_done,
   output logic [SEL_W:0]     hdr_word,
   output logic [FRAME_W-1:0] frame_word
);

   localparam logic [CW-1:0] LAST_SLOT = CW'(FRAME_W - 1);
   localparam logic [CW-1:0] HDR_SLOT  = CW'(SEL_W);

   logic [FRAME_W-2:0] shreg;

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         shreg <= '0;
      end else if (fsync_n) begin
         cnt   <= '0;
      end else begin
         cnt   <= (cnt == LAST_SLOT) ? '0 : cnt + 1'b1;
         shreg <= {shreg[FRAME_W-3:0], sdi};
      end
   end

   assign hdr_done   = !fsync_n && (cnt == HDR_SLOT);
   assign frame_done = !fsync_n && (cnt == LAST_SLOT);
   assign hdr_word   = {shreg[SEL_W-1:0], sdi};
   assign frame_word = {shreg, sdi};

endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank #(
   parameter int SEL_W     = 3,
   parameter int DATA_W    = 12,
   parameter int NUM_BANKS = 4
) (
   input  logic                        sclk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [SEL_W-1:0]            wr_sel,
   input  logic [DATA_W-1:0]           wr_data,
   output logic [NUM_BANKS*DATA_W-1:0] bank_flat
);

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_reg
      logic [DATA_W-1:0] q;

      always_ff @(posedge sclk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en && (wr_sel == SEL_W'(g)))
            q <= wr_data;
      end

      assign bank_flat[g*DATA_W +: DATA_W] = q;
   end

endmodule

// File: rtl/ctrl_rd_drive.sv
module ctrl_rd_drive #(
   parameter int SEL_W   = 3,
   parameter int DATA_W  = 12,
   parameter int FRAME_W = ctrl_serial_pkg::frame_bits(SEL_W, DATA_W),
   parameter int CW      = $clog2(FRAME_W)
) (
   input  logic              sclk,
   input  logic              rst_n,
   input  logic              fsync_n,
   input  logic [CW-1:0]     cnt,
   input  logic              hdr_done,
   input  logic              frame_done,
   input  logic              hdr_rw,
   input  logic [DATA_W-1:0] rd_data,
   output logic              sdo
);

   localparam logic [CW-1:0] DATA_SLOT = CW'(SEL_W + 1);

   logic              rd_act;
   logic [DATA_W-1:0] rd_word;
   logic [DATA_W-1:0] rd_aligned;
   logic              in_window;

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         rd_act  <= 1'b0;
         rd_word <= '0;
      end else if (fsync_n || frame_done) begin
         rd_act  <= 1'b0;
      end else if (hdr_done) begin
         rd_act  <= (hdr_rw == ctrl_serial_pkg::ACC_READ);
         rd_word <= rd_data;
      end
   end

   assign in_window  = !fsync_n && rd_act && (cnt >= DATA_SLOT);
   assign rd_aligned = rd_word << (cnt - DATA_SLOT);

   always_ff @(negedge sclk or negedge rst_n) begin
      if (!rst_n)
         sdo <= 1'b0;
      else
         sdo <= in_window & rd_aligned[DATA_W-1];
   end

endmodule

// File: rtl/ctrl_serial_regs.sv
module ctrl_serial_regs #(
   parameter int SEL_W     = 3,
   parameter int DATA_W    = 12,
   parameter int NUM_BANKS = 4
) (
   input  logic sclk,
   input  logic rst_n,
   input  logic fsync_n,
   input  logic sdi,
   output logic sdo
);

   localparam int FRAME_W = ctrl_serial_pkg::frame_bits(SEL_W, DATA_W);
   localparam int CW      = $clog2(FRAME_W);

   if (NUM_BANKS < 1 || NUM_BANKS > (1 << SEL_W)) begin : g_bad_banks
      $error("NUM_BANKS must lie between 1 and 2**SEL_W");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end

   logic [CW-1:0]               cnt;
   logic                        hdr_done;
   logic                        frame_done;
   logic [SEL_W:0]              hdr_word;
   logic [FRAME_W-1:0]          frame_word;
   logic                        wr_en;
   logic [SEL_W-1:0]            wr_sel;
   logic [DATA_W-1:0]           wr_data;
   logic [NUM_BANKS*DATA_W-1:0] bank_flat;
   logic [SEL_W-1:0]            rd_sel;
   logic [DATA_W-1:0]           rd_data;

   ctrl_frame_rx #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_rx (
      .sclk       (sclk),
      .rst_n      (rst_n),
      .fsync_n    (fsync_n),
      .sdi        (sdi),
      .cnt        (cnt),
      .hdr_done   (hdr_done),
      .frame_done (frame_done),
      .hdr_word   (hdr_word),
      .frame_word (frame_word)
   );

   assign wr_en   = frame_done && (frame_word[FRAME_W-1] == ctrl_serial_pkg::ACC_WRITE);
   assign wr_sel  = frame_word[FRAME_W-2 -: SEL_W];
   assign wr_data = frame_word[DATA_W-1:0];

   ctrl_reg_bank #(.SEL_W(SEL_W), .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS)) u_bank (
      .sclk      (sclk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .bank_flat (bank_flat)
   );

   assign rd_sel = hdr_word[SEL_W-1:0];

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_BANKS; i++) begin
         if (rd_sel == SEL_W'(i))
            rd_data = bank_flat[i*DATA_W +: DATA_W];
      end
   end

   ctrl_rd_drive #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_rd (
      .sclk       (sclk),
      .rst_n      (rst_n),
      .fsync_n    (fsync_n),
      .cnt        (cnt),
      .hdr_done   (hdr_done),
      .frame_done (frame_done),
      .hdr_rw     (hdr_word[SEL_W]),
      .rd_data    (rd_data),
      .sdo        (sdo)
   );

endmodule

// File: rtl/ctrl_serial_chk.sv
module ctrl_serial_chk #(
   parameter int SEL_W     = 3,
   parameter int DATA_W    = 12,
   parameter int NUM_BANKS = 4,
   parameter int CW        = 4
) (
   input logic                        sclk,
   input logic                        rst_n,
   input logic                        sdo,
   input logic [CW-1:0]               cnt,
   input logic                        wr_en,
   input logic [SEL_W-1:0]            wr_sel,
   input logic [DATA_W-1:0]           wr_data,
   input logic [NUM_BANKS*DATA_W-1:0] bank_flat
);

   logic [SEL_W-1:0]  last_sel;
   logic [DATA_W-1:0] last_data;

   always_ff @(posedge sclk) begin
      last_sel  <= wr_sel;
      last_data <= wr_data;
   end

   AST_NO_STRAY_WRITE: assert property (@(posedge sclk) disable iff (!rst_n)
      !wr_en |=> $stable(bank_flat)); // R6

   AST_UNUSED_SEL_IGNORED: assert property (@(posedge sclk) disable iff (!rst_n)
      (wr_en && int'(wr_sel) >= NUM_BANKS) |=> $stable(bank_flat)); // R5

   AST_WRITE_LANDS: assert property (@(posedge sclk) disable iff (!rst_n)
      (wr_en && int'(wr_sel) < NUM_BANKS) |=>
      (bank_flat[int'(last_sel)*DATA_W +: DATA_W] == last_data)); // R2

   AST_SDO_QUIET_HDR: assert property (@(posedge sclk) disable iff (!rst_n)
      (int'(cnt) <= SEL_W) |-> !sdo); // R4

   always_comb begin
      if (!rst_n) begin
         AST_RESET_SDO_LOW: assert (!sdo); // R7
      end
   end

endmodule

bind ctrl_serial_regs ctrl_serial_chk #(
   .SEL_W(SEL_W), .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .CW(CW)
) u_chk (
   .sclk      (sclk),
   .rst_n     (rst_n),
   .sdo       (sdo),
   .cnt       (cnt),
   .wr_en     (wr_en),
   .wr_sel    (wr_sel),
   .wr_data   (wr_data),
   .bank_flat (bank_flat)
);

// File: tb/sim_ctrl_serial_regs.sv
`timescale 1ns/1ps
module sim_ctrl_serial_regs;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fsync_n = 1'b1;
   logic sdi = 1'b0;
   logic sdo;

   int checks = 0;
   int fails = 0;
   logic [11:0] model [4];

   always #4 clk = ~clk;

   ctrl_serial_regs u0 (
      .sclk(clk), .rst_n(rst_n), .fsync_n(fsync_n), .sdi(sdi), .sdo(sdo)
   );

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      #1000000;
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      summary();
      $finish;
   end

   task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [11:0] exp_read(input logic [2:0] sel);
      return (sel < 3'd4) ? model[sel[1:0]] : 12'h000;
   endfunction

   // Shift nbits of a 16-bit frame; nbits < 16 models an early sync rise.
   task automatic frame(input bit rw, input logic [2:0] sel, input logic [11:0] dat,
                        input int nbits, output logic [11:0] got, output bit quiet);
      logic [15:0] w;
      w = {rw, sel, dat};
      got = '0;
      quiet = 1'b1;
      for (int i = 0; i < nbits; i++) begin
         @(negedge clk); #1;
         fsync_n = 1'b0;
         sdi = w[15-i];
         if (i >= 4) got[15-i] = sdo;
         if (i < 4 || !rw) quiet &= (sdo == 1'b0);
      end
      @(negedge clk); #1;
      if (nbits == 16) quiet &= (sdo == 1'b0);
      fsync_n = 1'b1;
      sdi = 1'b0;
      @(negedge clk); #1;
      quiet &= (sdo == 1'b0);
   endtask

   task automatic do_write(input logic [2:0] sel, input logic [11:0] dat, input string req);
      logic [11:0] g;
      bit q;
      frame(1'b0, sel, dat, 16, g, q);
      if (sel < 3'd4) model[sel[1:0]] = dat;
      chk({req, "/R4 write frame sdo quiet"}, {11'd0, q}, 12'd1);
   endtask

   task automatic do_read(input logic [2:0] sel, input string req);
      logic [11:0] g;
      bit q;
      frame(1'b1, sel, 12'h000, 16, g, q);
      chk(req, g, exp_read(sel));
      chk("R4 read header/tail sdo quiet", {11'd0, q}, 12'd1);
   endtask

   initial begin
      logic [11:0] g;
      bit q;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 4; i++) model[i] = '0;

      repeat (3) @(negedge clk);
      #1;
      chk("R7 sdo low in reset", {11'd0, sdo}, 12'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int b = 0; b < 4; b++) do_read(3'(b), "R7 reset value zero");

      do_write(3'd0, 12'hFFF, "R2");
      do_write(3'd1, 12'hA5A, "R2");
      do_write(3'd2, 12'h5A5, "R1");
      do_write(3'd3, 12'h801, "R1");
      for (int b = 0; b < 4; b++) do_read(3'(b), "R3 readback");
      do_read(3'd2, "R8 repeat read unchanged");

      for (int s = 4; s < 8; s++) begin
         do_write(3'(s), 12'h3C3, "R5");
         do_read(3'(s), "R5 unused code reads zero");
      end
      for (int b = 0; b < 4; b++) do_read(3'(b), "R5 unused write no effect");

      // Sync rises exactly where the 16th bit would be captured.
      frame(1'b0, 3'd1, 12'h123, 15, g, q);
      do_read(3'd1, "R6 abort at last bit");
      frame(1'b0, 3'd3, 12'h777, 4, g, q);
      do_read(3'd3, "R6 abort in data");
      frame(1'b1, 3'd0, 12'h000, 9, g, q);
      do_read(3'd0, "R6 aborted read harmless");

      for (int n = 0; n < 300; n++) begin
         logic [2:0] s;
         logic [11:0] d;
         int len;
         s = 3'($urandom_range(0, 7));
         d = 12'($urandom);
         len = ($urandom_range(0, 5) == 0) ? $urandom_range(1, 15) : 16;
         if ($urandom_range(0, 1) == 0) begin
            if (len == 16) do_write(s, d, "R2 random");
            else frame(1'b0, s, d, len, g, q);
         end else begin
            if (len == 16) do_read(s, "R3 random");
            else frame(1'b1, s, d, len, g, q);
         end
      end
      for (int b = 0; b < 4; b++) do_read(3'(b), "R6 random sweep");

      // Reset asserted in the middle of the data slots of a write frame.
      do_write(3'd2, 12'hBEE, "R2");
      @(negedge clk); #1;
      fsync_n = 1'b0;
      for (int i = 0; i < 8; i++) begin
         sdi = (i == 0) ? 1'b0 : 1'b1;
         @(negedge clk); #1;
      end
      rst_n = 1'b0;
      #2;
      chk("R7 async reset sdo low", {11'd0, sdo}, 12'd0);
      fsync_n = 1'b1;
      @(negedge clk); #1;
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) model[i] = '0;
      @(negedge clk);
      for (int b = 0; b < 4; b++) do_read(3'(b), "R7 cleared after reset");

      summary();
      $finish;
   end

endmodule